// File: doc/BRIEF.md
# Debug Breakpoint Combiner and Halt Controller

This block watches the core's instruction-fetch and data-access address strobes and compares each access against four breakpoint registers: two for the instruction class and two for the data class. Each class can work in one of two combine modes. In independent (OR) mode, each breakpoint drives its own indicator output. In paired (AND) mode, the class reports a single event on its second indicator output, and only once both breakpoints of the pair have matched. The two matches may come in the same cycle or in any order across cycles. A sticky flag remembers the first match of the pair.

The block also owns the core run/halt state. Any indicator event halts the core softly. An external halt pin, which may change at any time, passes through a synchronizer. Its rising edge halts the core. It is a hard stop when the hard-stop control bit is set, and a soft halt otherwise. A resume input returns the core to running. In a hard stop, resume is refused for as long as the synchronized pin stays high. While the core is halted, the stopped status output is high and the core clock enable is low.

The halt state machine has three states:
- RUN (running).
- SOFT (halted, resumable at any time).
- HARD (halted, resumable only once the external pin is low).

Its transitions are:
- RUN→HARD when the pin rises with hard-stop set.
- RUN→SOFT when the pin rises with hard-stop clear, or on an indicator event.
- SOFT→HARD when the pin rises with hard-stop set. This takes precedence over resume.
- SOFT→RUN on resume.
- HARD→RUN on resume with the synchronized pin low.

Top module: `dbg_bp_halt_ctrl`

## Requirements
- R1: After reset all indicators are low, `core_stopped` is 0, `core_clk_en` is 1, every breakpoint is disabled and both classes are in OR mode with hard-stop clear.
- R2: A register write takes effect only when `reg_we` and `reg_sup` are both high. The write map is:
  - address 0: instruction breakpoint 0;
  - address 1: instruction breakpoint 1;
  - address 2: data breakpoint 0;
  - address 3: data breakpoint 1;
  - address 4: control.

  For addresses 0 to 3, `reg_wdata[AW]` is the enable bit and `reg_wdata[AW-1:0]` is the address. In the control word, bit 0 selects AND mode for the instruction class, bit 1 selects AND mode for the data class, and bit 2 is hard-stop. A write with `reg_sup` low changes nothing.
- R3: In OR mode, an access that matches breakpoint i of a class raises that class's indicator bit i for exactly one cycle. The bit rises in the cycle after the clock edge that samples the access. No other indicator bit rises.
- R4: In AND mode, indicator bit 0 of the class stays low. Bit 1 pulses for one cycle after the access that completes the pair. The pair is complete when both breakpoints have matched, in the same access or in earlier accesses in either order.
- R5: In AND mode, the remembered first match is cleared when the combined indication fires, and also by any supervisor write to the control register.
- R6: A disabled breakpoint never matches. In AND mode it also never records a first match.
- R7: An indicator pulse halts the core softly. `core_stopped` rises and `core_clk_en` falls one cycle after the pulse.
- R8: `ext_halt_a` passes through two synchronizer flops. Its rising edge halts the core three clock edges after it is first sampled high.
- R9: If hard-stop is set when the external halt rises, the halt is hard. Resume has no effect while the synchronized pin is high, and is honoured once the pin is low.
- R10: From a soft halt, `resume` returns the core to running at the next edge, even while the external pin is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sup | input | 1 | Supervisor-mode qualifier for the write |
| reg_addr | input | 3 | Register select (0-3 breakpoints, 4 control) |
| reg_wdata | input | AW+1 | Write data (enable bit on top of the address) |
| fetch_vld | input | 1 | Instruction-fetch address strobe |
| fetch_addr | input | AW | Instruction-fetch address |
| data_vld | input | 1 | Data-access address strobe |
| data_addr | input | AW | Data-access address |
| ext_halt_a | input | 1 | Asynchronous external halt request |
| resume | input | 1 | Leave the halted state |
| bp_ifetch_hit | output | 2 | Instruction breakpoint indicators |
| bp_data_hit | output | 2 | Data breakpoint indicators |
| core_stopped | output | 1 | High while the core is halted |
| core_clk_en | output | 1 | Core clock gate enable, low while halted |

## Verification
The hardest situation to reach from the ports is a sticky first match that survives one or more intervening accesses in AND mode. Reaching it needs the right mode, two enabled breakpoints and an ordered series of accesses. Every access that completes the pair also halts the core, and the core has to be resumed before the next series starts. The bench sweeps every ordered pair of accesses, drawn from miss, first breakpoint and second breakpoint, in both modes and both classes. Each series is preceded by a control rewrite that empties the flags, and each is closed by a resume. A separate series exercises flag clearing by a control rewrite in the middle of a pair.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    localparam int NBP        = 4;
    localparam int NPAIR      = 2;
    localparam logic [2:0] REG_CTRL = 3'd4;
    localparam int CTRL_IAND  = 0;
    localparam int CTRL_DAND  = 1;
    localparam int CTRL_HARD  = 2;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_SOFT = 2'd1,
        ST_HARD = 2'd2
    } halt_st_e;

endpackage

// File: rtl/dbg_bp_regs.sv
module dbg_bp_regs
    import dbg_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic                     sup,
    input  logic [2:0]               addr,
    input  logic [AW:0]              wdata,
    output logic [NBP-1:0][AW-1:0]   bp_addr,
    output logic [NBP-1:0]           bp_en,
    output logic [NPAIR-1:0]         and_mode,
    output logic                     hardstop,
    output logic                     ctrl_wr
);

    logic wr_ok;
    assign wr_ok   = we && sup;
    assign ctrl_wr = wr_ok && (addr == REG_CTRL);

    for (genvar g = 0; g < NBP; g++) begin : g_bp
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bp_addr[g] <= '0;
                bp_en[g]   <= 1'b0;
            end else if (wr_ok && (addr == 3'(g))) begin
                bp_addr[g] <= wdata[AW-1:0];
                bp_en[g]   <= wdata[AW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            and_mode <= '0;
            hardstop <= 1'b0;
        end else if (ctrl_wr) begin
            and_mode <= {wdata[CTRL_DAND], wdata[CTRL_IAND]};
            hardstop <= wdata[CTRL_HARD];
        end
    end

    // R2: a write without the supervisor qualifier leaves every field untouched
    a_r2_nonsup_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !sup) |=> ($stable(bp_en) && $stable(bp_addr) &&
                          $stable(and_mode) && $stable(hardstop)));

endmodule

// File: rtl/dbg_bp_pair.sv
module dbg_bp_pair
    import dbg_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_vld,
    input  logic [AW-1:0]     acc_addr,
    input  logic [1:0][AW-1:0] bp_addr,
    input  logic [1:0]        bp_en,
    input  logic              and_mode,
    input  logic              clr,
    output logic [1:0]        ind
);

    logic [1:0] hit;
    logic [1:0] flag_q;
    logic [1:0] ind_q;
    logic       fire;

    for (genvar i = 0; i < 2; i++) begin : g_cmp
        assign hit[i] = acc_vld && bp_en[i] && (acc_addr == bp_addr[i]);
    end

    assign fire = (hit[0] || flag_q[0]) && (hit[1] || flag_q[1]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else if (clr || (and_mode && fire)) begin
            flag_q <= '0;
        end else if (and_mode) begin
            flag_q <= flag_q | hit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ind_q <= '0;
        end else if (and_mode) begin
            ind_q <= {fire, 1'b0};
        end else begin
            ind_q <= hit;
        end
    end

    assign ind = ind_q;

    // R3: in OR mode an indicator only follows its own comparator
    a_r3_or_own: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_q[0] && !$past(and_mode)) |-> $past(hit[0]));

    // R4: the first indicator of a pair is silent in AND mode
    a_r4_and_first_low: assert property (@(posedge clk) disable iff (!rst_n)
        ind_q[0] |-> !$past(and_mode));

    // R5: a control rewrite empties the remembered matches
    a_r5_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (flag_q == 2'b00));

endmodule

// File: rtl/dbg_halt_fsm.sv
module dbg_halt_fsm
    import dbg_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_halt_a,
    input  logic hardstop,
    input  logic bp_evt,
    input  logic resume,
    output logic stopped,
    output logic clk_en
);

    logic [SYNC-1:0] sync_q;
    logic            ext_s;
    logic            ext_d;
    logic            ext_rise;
    halt_st_e        state_q;
    halt_st_e        state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            ext_d  <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC-2:0], ext_halt_a};
            ext_d  <= ext_s;
        end
    end

    assign ext_s    = sync_q[SYNC-1];
    assign ext_rise = ext_s && !ext_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (ext_rise)    state_d = hardstop ? ST_HARD : ST_SOFT;
                else if (bp_evt) state_d = ST_SOFT;
            end
            ST_SOFT: begin
                if (ext_rise && hardstop) state_d = ST_HARD;
                else if (resume)          state_d = ST_RUN;
            end
            ST_HARD: begin
                if (resume && !ext_s)     state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        stopped = 1'b1;
        clk_en  = 1'b0;
        unique case (state_q)
            ST_RUN:  begin stopped = 1'b0; clk_en = 1'b1; end
            ST_SOFT: begin stopped = 1'b1; clk_en = 1'b0; end
            ST_HARD: begin stopped = 1'b1; clk_en = 1'b0; end
            default: begin stopped = 1'b1; clk_en = 1'b0; end
        endcase
    end

    // R7: an indicator event while running always halts
    a_r7_bp_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && bp_evt) |=> (state_q != ST_RUN));

    // R9: hard stop holds while the synchronized pin is high
    a_r9_hard_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HARD && ext_s) |=> (state_q == ST_HARD));

    // R10: resume from a soft halt is honoured at the next edge
    a_r10_soft_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SOFT && resume && !(ext_rise && hardstop)) |=> (state_q == ST_RUN));

endmodule

// File: rtl/dbg_bp_halt_ctrl.sv
module dbg_bp_halt_ctrl
    import dbg_pkg::*;
#(
    parameter int AW   = 32,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic          reg_sup,
    input  logic [2:0]    reg_addr,
    input  logic [AW:0]   reg_wdata,
    input  logic          fetch_vld,
    input  logic [AW-1:0] fetch_addr,
    input  logic          data_vld,
    input  logic [AW-1:0] data_addr,
    input  logic          ext_halt_a,
    input  logic          resume,
    output logic [1:0]    bp_ifetch_hit,
    output logic [1:0]    bp_data_hit,
    output logic          core_stopped,
    output logic          core_clk_en
);

    logic [NBP-1:0][AW-1:0] bp_addr;
    logic [NBP-1:0]         bp_en;
    logic [NPAIR-1:0]       and_mode;
    logic                   hardstop;
    logic                   ctrl_wr;
    logic [NPAIR-1:0]       acc_vld;
    logic [NPAIR-1:0][AW-1:0] acc_addr;
    logic [NPAIR-1:0][1:0]  ind;

    assign acc_vld  = {data_vld, fetch_vld};
    assign acc_addr = {data_addr, fetch_addr};

    dbg_bp_regs #(.AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .sup      (reg_sup),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .bp_addr  (bp_addr),
        .bp_en    (bp_en),
        .and_mode (and_mode),
        .hardstop (hardstop),
        .ctrl_wr  (ctrl_wr)
    );

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        dbg_bp_pair #(.AW(AW)) u_pair (
            .clk      (clk),
            .rst_n    (rst_n),
            .acc_vld  (acc_vld[p]),
            .acc_addr (acc_addr[p]),
            .bp_addr  (bp_addr[2*p+1 -: 2]),
            .bp_en    (bp_en[2*p+1 -: 2]),
            .and_mode (and_mode[p]),
            .clr      (ctrl_wr),
            .ind      (ind[p])
        );
    end

    assign bp_ifetch_hit = ind[0];
    assign bp_data_hit   = ind[1];

    dbg_halt_fsm #(.SYNC(SYNC)) u_halt (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_halt_a (ext_halt_a),
        .hardstop   (hardstop),
        .bp_evt     (|ind),
        .resume     (resume),
        .stopped    (core_stopped),
        .clk_en     (core_clk_en)
    );

endmodule

// File: tb/test_dbg_bp_halt_ctrl.sv
module test_dbg_bp_halt_ctrl;

    localparam int AW = 32;
    localparam logic [AW-1:0] MISS = 32'h0000_5550;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0, reg_sup = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [AW:0]   reg_wdata = '0;
    logic          fetch_vld = 1'b0, data_vld = 1'b0;
    logic [AW-1:0] fetch_addr = '0, data_addr = '0;
    logic          ext_halt_a = 1'b0, resume = 1'b0;
    logic [1:0]    bp_ifetch_hit, bp_data_hit;
    logic          core_stopped, core_clk_en;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    dbg_bp_halt_ctrl #(.AW(AW)) i_dbg_bp_halt_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sup(reg_sup),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
        .data_vld(data_vld), .data_addr(data_addr),
        .ext_halt_a(ext_halt_a), .resume(resume),
        .bp_ifetch_hit(bp_ifetch_hit), .bp_data_hit(bp_data_hit),
        .core_stopped(core_stopped), .core_clk_en(core_clk_en)
    );

    function automatic logic [AW-1:0] bp_a(int c, int k);
        return 32'h0000_1000 + AW'(c) * 32'h0001_0000 + AW'(k) * 32'h0000_0100;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [AW:0] d, logic sup);
        reg_we = 1'b1; reg_sup = sup; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_sup = 1'b0;
    endtask

    // one access of class c to address x; returns indicators of both classes
    task automatic acc(int c, logic [AW-1:0] x, output logic [1:0] ih, output logic [1:0] dh);
        if (c == 0) begin fetch_vld = 1'b1; fetch_addr = x; end
        else        begin data_vld  = 1'b1; data_addr  = x; end
        @(negedge clk);
        fetch_vld = 1'b0; data_vld = 1'b0;
        ih = bp_ifetch_hit; dh = bp_data_hit;
    endtask

    task automatic do_resume();
        resume = 1'b1;
        @(negedge clk);
        resume = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual expired expected done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [1:0] ih, dh, exp, fl;
        logic any, h0, h1, fire;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 stopped", core_stopped, 0);
        check("R1 clk_en", core_clk_en, 1);
        check("R1 ind", {bp_ifetch_hit, bp_data_hit}, 0);
        acc(0, 32'h0, ih, dh);
        check("R1 disabled at reset", ih, 0);

        // R2 program breakpoints with supervisor writes
        for (int c = 0; c < 2; c++)
            for (int k = 0; k < 2; k++)
                wr(3'(2*c+k), {1'b1, bp_a(c, k)}, 1'b1);
        // R2 non-supervisor write must not move instruction breakpoint 0
        wr(3'd0, {1'b1, MISS}, 1'b0);
        acc(0, MISS, ih, dh);
        check("R2 nonsup addr ignored", ih, 0);
        acc(0, bp_a(0, 0), ih, dh);
        check("R2 old addr kept", ih, 2'b01);
        @(negedge clk);
        check("R7 stopped after pulse", core_stopped, 1);
        check("R7 clk_en low", core_clk_en, 0);
        check("R3 one-cycle pulse", ih & bp_ifetch_hit, 0);
        do_resume();
        check("R10 resume", core_stopped, 0);

        // R3/R4 sweep: class, mode, ordered pair of accesses
        for (int c = 0; c < 2; c++) begin
            for (int m = 0; m < 2; m++) begin
                for (int a = 0; a < 3; a++) begin
                    for (int b = 0; b < 3; b++) begin
                        wr(3'd4, (m != 0) ? AW'(1 << c) : '0, 1'b1);
                        fl = 2'b00; any = 1'b0;
                        for (int s = 0; s < 2; s++) begin
                            automatic int sel = (s == 0) ? a : b;
                            h0 = (sel == 1); h1 = (sel == 2);
                            acc(c, (sel == 0) ? MISS : bp_a(c, sel - 1), ih, dh);
                            if (m == 0) begin
                                exp = {h1, h0};
                            end else begin
                                fire = (h0 | fl[0]) & (h1 | fl[1]);
                                exp = {fire, 1'b0};
                                fl = fire ? 2'b00 : (fl | {h1, h0});
                            end
                            any |= |exp;
                            check(m ? "R4 and-mode ind" : "R3 or-mode ind",
                                  (c == 0) ? ih : dh, exp);
                            check("R3 other class quiet", (c == 0) ? dh : ih, 0);
                        end
                        @(negedge clk);
                        check("R7 halt after event", core_stopped, any);
                        do_resume();
                        check("R10 running again", core_stopped, 0);
                    end
                end
            end
        end

        // R5 control rewrite clears a first match
        wr(3'd4, 32'h1, 1'b1);
        acc(0, bp_a(0, 0), ih, dh);
        wr(3'd4, 32'h1, 1'b1);
        acc(0, bp_a(0, 1), ih, dh);
        check("R5 flag cleared by ctrl write", ih, 0);
        acc(0, bp_a(0, 0), ih, dh);
        check("R5 pair completes after rewrite", ih, 2'b10);
        @(negedge clk);
        do_resume();

        // R4 both data breakpoints on one address: single access completes pair
        wr(3'd3, {1'b1, bp_a(1, 0)}, 1'b1);
        wr(3'd4, 32'h2, 1'b1);
        acc(1, bp_a(1, 0), ih, dh);
        check("R4 same-cycle pair", dh, 2'b10);
        @(negedge clk);
        do_resume();
        wr(3'd3, {1'b1, bp_a(1, 1)}, 1'b1);

        // R6 disabled breakpoint: no match, no flag
        wr(3'd0, {1'b0, bp_a(0, 0)}, 1'b1);
        wr(3'd4, 32'h0, 1'b1);
        acc(0, bp_a(0, 0), ih, dh);
        check("R6 disabled no ind", ih, 0);
        @(negedge clk);
        check("R6 no halt", core_stopped, 0);
        wr(3'd4, 32'h1, 1'b1);
        acc(0, bp_a(0, 0), ih, dh);
        acc(0, bp_a(0, 1), ih, dh);
        check("R6 disabled sets no flag", ih, 0);
        wr(3'd4, 32'h0, 1'b1);

        // R8 soft external halt with synchronizer latency, R10 resume while held
        ext_halt_a = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R8 not yet halted", core_stopped, 0);
        @(negedge clk);
        check("R8 halted by pin", core_stopped, 1);
        do_resume();
        check("R10 soft resume with pin high", core_stopped, 0);
        repeat (2) @(negedge clk);
        check("R10 stays running", core_stopped, 0);
        ext_halt_a = 1'b0;
        repeat (3) @(negedge clk);

        // R9 hard stop
        wr(3'd4, 32'h4, 1'b1);
        ext_halt_a = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 hard halted", core_stopped, 1);
        do_resume();
        check("R9 resume refused", core_stopped, 1);
        ext_halt_a = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 still stopped", core_clk_en, 0);
        do_resume();
        check("R9 resume after release", core_stopped, 0);
        check("R9 clk_en back", core_clk_en, 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule